// File: doc/BRIEF.md
# Next fetch address and branch resolution unit

This unit holds the program counter of a fixed-length 32-bit instruction stream. Each cycle it works out the address to fetch next. A decoded control-transfer code selects the target. The target is the straight-line successor, a PC-relative branch target, an absolute jump target built from a 26-bit field, or a full address taken from a register. Conditional branches are resolved inside the unit without a subtractor. A condition is either an equality test between two register operands or a test of one operand against zero. The zero test uses only that operand's sign bit and an all-zero detect.

A decode stage places the control code and operands on the inputs. The unit answers combinationally with the next address and a taken flag. The PC register loads that address on every clock edge where the enable input is high.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, and on the first edge after it is released with `en_i` low, `pc_o` equals the reset vector 0x0000_1000.
- R2: For control code 0 (sequential) and for the unused codes 9 to 15, `next_pc_o` is `pc_o + 4` and `taken_o` is 0.
- R3: Code 1 (branch when equal) is taken when `rs_val_i == rt_val_i`. Code 2 (branch when not equal) is taken when the two operands differ.
- R4: The zero tests look at `rs_val_i` as a signed value and ignore `rt_val_i`. Code 3 is taken when the value is greater than zero, code 4 when it is greater than or equal to zero, code 5 when it is less than zero, and code 6 when it is less than or equal to zero.
- R5: A taken branch (codes 1 to 6) gives `next_pc_o = pc_o + 4 + (sign_extend(br_off_i) << 2)`. A branch that is not taken gives `pc_o + 4`.
- R6: Code 7 (absolute jump) is always taken. Its `next_pc_o` is bits 31:28 of `pc_o + 4`, followed by `jmp_fld_i`, followed by two zero bits.
- R7: Code 8 (indirect jump) is always taken. Its `next_pc_o` equals `ind_tgt_i` in all 32 bits, with no alignment applied.
- R8: On a rising clock edge with `en_i` high, `pc_o` takes the value `next_pc_o` had before that edge. With `en_i` low, `pc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the reset vector |
| en_i | input | 1 | Advance the PC this cycle |
| ctl_i | input | 4 | Control-transfer code (0 to 8, others sequential) |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| br_off_i | input | 16 | Branch offset in instructions, signed |
| jmp_fld_i | input | 26 | Absolute jump target field |
| ind_tgt_i | input | 32 | Indirect target register value |
| pc_o | output | 32 | Current PC |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Control transfer redirects the stream |

## Verification
Most of the logic is combinational. A fault in condition evaluation or target formation therefore shows on `taken_o` or `next_pc_o` in the same cycle that the control code is presented. A corrupted PC register shows on `pc_o` one edge after an enabled cycle. Every later successor address then inherits the error, because targets are relative to the PC. The bench mixes random operands with directed cases such as zero, the most negative value, equal operands, and offsets at both extremes. This makes a flipped sign test or a dropped zero detect visible at once.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    CT_SEQ  = 4'd0,
    CT_BEQ  = 4'd1,
    CT_BNE  = 4'd2,
    CT_BGTZ = 4'd3,
    CT_BGEZ = 4'd4,
    CT_BLTZ = 4'd5,
    CT_BLEZ = 4'd6,
    CT_JABS = 4'd7,
    CT_JIND = 4'd8
  } ctl_e;

  typedef enum logic [1:0] {
    TS_SEQ = 2'd0,
    TS_REL = 2'd1,
    TS_ABS = 2'd2,
    TS_IND = 2'd3
  } tsel_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      ctl_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            take_o,
  output tsel_e           tsel_o
);
  logic neg, zero, eq;

  assign neg  = rs_i[XLEN-1];
  assign zero = ~|rs_i;
  assign eq   = ~|(rs_i ^ rt_i);

  always_comb begin
    take_o = 1'b0;
    tsel_o = TS_SEQ;
    case (ctl_i)
      CT_BEQ:  begin take_o = eq;            tsel_o = TS_REL; end
      CT_BNE:  begin take_o = ~eq;           tsel_o = TS_REL; end
      CT_BGTZ: begin take_o = ~neg & ~zero;  tsel_o = TS_REL; end
      CT_BGEZ: begin take_o = ~neg;          tsel_o = TS_REL; end
      CT_BLTZ: begin take_o = neg;           tsel_o = TS_REL; end
      CT_BLEZ: begin take_o = neg | zero;    tsel_o = TS_REL; end
      CT_JABS: begin take_o = 1'b1;          tsel_o = TS_ABS; end
      CT_JIND: begin take_o = 1'b1;          tsel_o = TS_IND; end
      default: begin take_o = 1'b0;          tsel_o = TS_SEQ; end
    endcase
  end

  // R4
  always_comb begin
    if (ctl_i == CT_BGTZ && take_o)
      gtz_sign_chk: assert ($signed(rs_i) > 0);
  end

  // R3
  always_comb begin
    if (ctl_i == CT_BEQ && rs_i != rt_i)
      beq_diff_chk: assert (!take_o);
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JF_W  = 26
) (
  input  logic [XLEN-1:0]  pc4_i,
  input  tsel_e            tsel_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [JF_W-1:0]  fld_i,
  input  logic [XLEN-1:0]  ind_i,
  output logic [XLEN-1:0]  tgt_o
);
  localparam int SEXT_W = XLEN - OFF_W - 2;
  localparam int HI_W   = XLEN - JF_W - 2;

  logic [XLEN-1:0] rel_tgt, abs_tgt;

  assign rel_tgt = pc4_i + {{SEXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign abs_tgt = {pc4_i[XLEN-1 -: HI_W], fld_i, 2'b00};

  always_comb begin
    case (tsel_i)
      TS_REL:  tgt_o = rel_tgt;
      TS_ABS:  tgt_o = abs_tgt;
      TS_IND:  tgt_o = ind_i;
      default: tgt_o = pc4_i;
    endcase
  end

  // R6
  always_comb begin
    if (tsel_i == TS_ABS)
      abs_align_chk: assert (tgt_o[1:0] == 2'b00 && tgt_o[XLEN-1 -: HI_W] == pc4_i[XLEN-1 -: HI_W]);
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          OFF_W     = 16,
  parameter int          JF_W      = 26,
  parameter int          ILEN_B    = 4,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [3:0]       ctl_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [OFF_W-1:0] br_off_i,
  input  logic [JF_W-1:0]  jmp_fld_i,
  input  logic [XLEN-1:0]  ind_tgt_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             taken_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN_B);
  localparam logic [XLEN-1:0] RVEC = XLEN'(RESET_VEC);

  logic [XLEN-1:0] pc_q, pc4, tgt;
  logic            take;
  tsel_e           tsel;

  assign pc4 = pc_q + STEP;

  npc_cond #(.XLEN(XLEN)) u_cond (
    .ctl_i  (ctl_i),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .take_o (take),
    .tsel_o (tsel)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JF_W(JF_W)) u_tgt (
    .pc4_i  (pc4),
    .tsel_i (tsel),
    .off_i  (br_off_i),
    .fld_i  (jmp_fld_i),
    .ind_i  (ind_tgt_i),
    .tgt_o  (tgt)
  );

  // not-taken branches fall through
  assign next_pc_o = take ? tgt : pc4;
  assign taken_o   = take;
  assign pc_o      = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= RVEC;
    else if (en_i) pc_q <= next_pc_o;
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pc_o));

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !taken_o) |=> pc_o == $past(pc_o) + STEP);

  // R7
  ind_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ctl_i == CT_JIND) |=> pc_o == $past(ind_tgt_i));
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  ctl_i = '0;
  logic [31:0] rs_val_i = '0, rt_val_i = '0, ind_tgt_i = '0;
  logic [15:0] br_off_i = '0;
  logic [25:0] jmp_fld_i = '0;
  logic [31:0] pc_o, next_pc_o;
  logic        taken_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_pc;

  always #2.5 clk_i = ~clk_i;

  npc_unit u0 (.*);

  function automatic logic [32:0] model(logic [31:0] pc, logic [3:0] c, logic [31:0] a,
                                        logic [31:0] b, logic [15:0] off,
                                        logic [25:0] fld, logic [31:0] ind);
    logic [31:0] p4 = pc + 32'd4;
    logic [31:0] rel = p4 + {{14{off[15]}}, off, 2'b00};
    logic t;
    case (c)
      4'd1: t = (a == b);
      4'd2: t = (a != b);
      4'd3: t = ($signed(a) > 0);
      4'd4: t = ($signed(a) >= 0);
      4'd5: t = ($signed(a) < 0);
      4'd6: t = ($signed(a) <= 0);
      4'd7: return {1'b1, p4[31:28], fld, 2'b00};
      4'd8: return {1'b1, ind};
      default: return {1'b0, p4};
    endcase
    return {t, t ? rel : p4};
  endfunction

  function automatic string tag(logic [3:0] c);
    case (c)
      4'd1, 4'd2: return "R3/R5";
      4'd3, 4'd4, 4'd5, 4'd6: return "R4/R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string r, logic [32:0] act, logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // drive one cycle and check combinational result, then the registered PC
  task automatic step(logic en, logic [3:0] c, logic [31:0] a, logic [31:0] b,
                      logic [15:0] off, logic [25:0] fld, logic [31:0] ind);
    logic [32:0] e;
    @(negedge clk_i);
    en_i = en; ctl_i = c; rs_val_i = a; rt_val_i = b;
    br_off_i = off; jmp_fld_i = fld; ind_tgt_i = ind;
    #1;
    e = model(exp_pc, c, a, b, off, fld, ind);
    chk(tag(c), {taken_o, next_pc_o}, e);
    @(posedge clk_i); #1;
    if (en) exp_pc = e[31:0];
    chk("R8", {1'b0, pc_o}, {1'b0, exp_pc});
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    exp_pc = 32'h0000_1000;
    repeat (3) @(posedge clk_i);
    #1 chk("R1", {1'b0, pc_o}, {1'b0, 32'h0000_1000});
    @(negedge clk_i) rst_ni = 1'b1;
    step(1'b0, 4'd0, 0, 0, 0, 0, 0);                        // R1 holds after release
    step(1'b1, 4'd0, 0, 0, 0, 0, 0);                        // R2
    step(1'b1, 4'd12, 5, 5, 16'h7fff, 0, 0);                // R2 unused code
    step(1'b1, 4'd1, 32'h1234, 32'h1234, 16'h8000, 0, 0);   // R3 equal, max negative offset
    step(1'b1, 4'd2, 32'h1234, 32'h1234, 16'h0010, 0, 0);   // R3 not taken
    step(1'b1, 4'd3, 32'h0, 32'h5, 16'h0004, 0, 0);         // R4 zero not >0
    step(1'b1, 4'd4, 32'h0, 32'h0, 16'h7fff, 0, 0);         // R4 zero >=0
    step(1'b1, 4'd5, 32'h8000_0000, 0, 16'hfffe, 0, 0);     // R4 most negative
    step(1'b1, 4'd6, 32'h0, 32'h0, 16'h0003, 0, 0);         // R4 zero <=0
    step(1'b1, 4'd3, 32'h7fff_ffff, 0, 16'h0001, 0, 0);     // R4 max positive
    step(1'b1, 4'd7, 0, 0, 0, 26'h3ff_ffff, 0);             // R6
    step(1'b1, 4'd8, 0, 0, 0, 0, 32'hdead_beef);            // R7 unaligned kept
    step(1'b0, 4'd8, 0, 0, 0, 0, 32'h0000_0040);            // R8 hold
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: a = 32'h0;
        1: a = 32'h8000_0000 | $urandom;
        2: a = $urandom_range(0, 8);
        default: a = $urandom;
      endcase
      b = ($urandom_range(0, 2) == 0) ? a : $urandom;
      step(($urandom_range(0, 4) != 0), c, a, b, 16'($urandom),
           26'($urandom), $urandom);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule